// File: doc/BRIEF.md
# DMA-Aware Memory Page Mapper

This block sits between an 8-bit processor, a DMA engine and a memory array of up to 256 KB. It splits the 64 KB logical address space into sixteen 4 KB pages. For each page it returns a 6-bit physical page number, with one number used for reads and a separate one used for writes. The lookup goes through two 512-entry translation tables that are loaded through a simple programming port. The table index is built from an 8-bit bank-control register and the page number taken from the top four address bits.

The block also arbitrates the bus between the CPU and the DMA engine. A DMA bus request is granted on the next clock. While the grant is active, the CPU is held off, and a DMA bank field in the bank-control register replaces the CPU bank field in the table index. Dropping the request gives the bus back to the CPU and restores the CPU mapping.

A boot-mode flag is set by reset and cleared by a pulse on a dedicated input. Reset also clears the bank-control register.

Top module: `mmu_bank_mapper`

## Requirements
- R1: While `rst_n` is low at a clock edge, the bank-control register becomes 0x00, `boot_mode` becomes 1, and `dma_grant` and `cpu_hold` become 0.
- R2: A clock edge with `cfg_wr` high loads `cfg_data` into the bank-control register, and translations use the new value from the following cycle. With `cfg_wr` low, `cfg_data` has no effect on either translation.
- R3: When the DMA does not own the bus, the 9-bit table index has four fields:
  - bit 8 is the inverse of bank bit 5 (write-protect enable);
  - bits 7:6 are bank bits 2:1 (template);
  - bits 5:4 are bank bits 4:3 (CPU bank);
  - bits 3:0 are `addr_in[15:12]`.
- R4: When `dma_grant` is 1, index bits 5:4 come from bank bits 7:6 (DMA bank). All other index bits are unchanged.
- R5: `dma_grant` and `cpu_hold` both become 1 on the clock edge after `dma_req` is sampled high. Both become 0 on the edge after `dma_req` is sampled low. In the cycle where the grant changes, the translation already follows the new bus owner.
- R6: Read and write translations come from two separate tables. A table write with `tbl_sel`=0 changes only the read table, and `tbl_sel`=1 changes only the write table.
- R7: Each table entry keeps only bits 5:0 of `tbl_wdata`. The outputs are `rd_phys = {read_entry, addr_in[11:0]}` and `wr_phys = {write_entry, addr_in[11:0]}`.
- R8: A clock edge with `boot_clr` high clears `boot_mode`. After that, `boot_mode` stays 0 until the next reset.
- R9: Bank-control bit 0 has no effect on either translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Load strobe for the bank-control register |
| cfg_data | input | 8 | New bank-control value |
| boot_clr | input | 1 | Clears the boot-mode flag |
| dma_req | input | 1 | DMA bus request |
| dma_grant | output | 1 | Bus granted to the DMA |
| cpu_hold | output | 1 | Holds the CPU off the bus |
| boot_mode | output | 1 | Boot-mode flag |
| tbl_we | input | 1 | Table write enable |
| tbl_sel | input | 1 | Table select: 0 = read table, 1 = write table |
| tbl_addr | input | 9 | Table entry index |
| tbl_wdata | input | 8 | Table entry data (only bits 5:0 are stored) |
| addr_in | input | 16 | Logical address from the CPU or DMA |
| rd_phys | output | 18 | Physical address for reads |
| wr_phys | output | 18 | Physical address for writes |

## Verification
Some properties are checked on every cycle by assertions:
- the register load;
- the one-cycle grant and hold response to the request;
- the one-way clearing of the boot flag;
- the storage of masked table data.

The composition of the index is only shown by the bench's scenarios. This covers the inverted write-protect bit, the template and bank fields, and the swap to the DMA bank under grant. The bench drives random bank values, requests and addresses and compares both physical addresses against its own model of the tables. Directed cases cover the remaining behaviour:
- that bit 0 has no effect;
- that `cfg_data` is ignored without a strobe;
- that the two tables are independent;
- the state after a second reset.

// File: rtl/mmu_bank_pkg.sv
// Package: shared widths, the bank-control layout and the index builder.
// Assumes 4 KB pages over a 16-bit logical space, with 6-bit physical pages.
package mmu_bank_pkg;
    localparam int VA_W    = 16;
    localparam int PG_W    = 4;
    localparam int OFS_W   = VA_W - PG_W;
    localparam int PPN_W   = 6;
    localparam int CFG_W   = 8;
    localparam int IDX_W   = 1 + 2 + 2 + PG_W;
    localparam int TDATA_W = 8;

    // Bank-control layout, MSB first: DMA bank, write-protect enable, CPU bank, template, spare.
    typedef struct packed {
        logic [1:0] dma_bank;
        logic       wp_en;
        logic [1:0] cpu_bank;
        logic [1:0] tmpl;
        logic       spare;
    } bank_cfg_t;

    // Builds the table index. The page number fills the low bits, so consecutive pages use consecutive entries.
    function automatic logic [IDX_W-1:0] map_index(
        input bank_cfg_t         cfg,
        input logic              dma_own,
        input logic [PG_W-1:0]   page
    );
        logic [1:0] bank_sel;
        bank_sel = dma_own ? cfg.dma_bank : cfg.cpu_bank;
        return {~cfg.wp_en, cfg.tmpl, bank_sel, page};
    endfunction
endpackage

// File: rtl/mmu_ctrl_regs.sv
// Module: control state of the mapper. It holds:
//   - the bank-control register;
//   - the boot-mode flag;
//   - the registered bus-owner flag.
// Assumes the request is granted one clock after it is sampled, with no wait.
module mmu_ctrl_regs #(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             boot_clr,
    input  logic             dma_req,
    output logic [CFG_W-1:0] bank_q,
    output logic             boot_q,
    output logic             dma_own_q
);
    // Bank-control register: cleared by reset, loaded by strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bank_q <= '0;
        else if (cfg_wr) bank_q <= cfg_data;
    end

    // Boot flag: set by reset, cleared by a pulse on boot_clr.
    always_ff @(posedge clk) begin
        if (!rst_n)        boot_q <= 1'b1;
        else if (boot_clr) boot_q <= 1'b0;
    end

    // Bus-owner flag: registered so that the index only changes on a clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) dma_own_q <= 1'b0;
        else        dma_own_q <= dma_req;
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bank_q == '0) && boot_q && !dma_own_q);
    p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> bank_q == $past(cfg_data));
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(bank_q));
    p_grant_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> dma_own_q);
    p_grant_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_req |=> !dma_own_q);
    p_boot_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        boot_clr |=> !boot_q);
    p_boot_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_q |=> !boot_q);
endmodule

// File: rtl/mmu_page_table.sv
// Module: one translation table with a synchronous write and a combinational read.
// Assumes only the low PPN_W bits of the write data are meaningful, so the rest are dropped.
module mmu_page_table #(
    parameter int IDX_W  = 9,
    parameter int PPN_W  = 6,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [PPN_W-1:0]  rdata
);
    logic [PPN_W-1:0] mem [DEPTH];
    logic [DATA_W-PPN_W-1:0] unused_hi;
    assign unused_hi = wdata[DATA_W-1:PPN_W];

    // Table update: store the masked page value.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata[PPN_W-1:0];
    end

    // Lookup for the current index.
    always_comb rdata = mem[raddr];

    p_masked_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata[PPN_W-1:0]));
endmodule

// File: rtl/mmu_bank_mapper.sv
// Module: top of the mapper. It:
//   - builds the table index from the bank register, the bus owner and the page number;
//   - looks the index up in separate read and write tables;
//   - appends the page offset to each result.
// Assumes the DMA and the CPU share addr_in, and that only the current bus owner drives it.
module mmu_bank_mapper
    import mmu_bank_pkg::*;
#(
    parameter int VA_BITS  = VA_W,
    parameter int PPN_BITS = PPN_W,
    parameter int TD_BITS  = TDATA_W,
    localparam int OFS_BITS = VA_BITS - PG_W,
    localparam int PA_BITS  = PPN_BITS + OFS_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [CFG_W-1:0]    cfg_data,
    input  logic                boot_clr,
    input  logic                dma_req,
    output logic                dma_grant,
    output logic                cpu_hold,
    output logic                boot_mode,
    input  logic                tbl_we,
    input  logic                tbl_sel,
    input  logic [IDX_W-1:0]    tbl_addr,
    input  logic [TD_BITS-1:0]  tbl_wdata,
    input  logic [VA_BITS-1:0]  addr_in,
    output logic [PA_BITS-1:0]  rd_phys,
    output logic [PA_BITS-1:0]  wr_phys
);
    logic [CFG_W-1:0]    bank_q;
    logic                dma_own_q;
    logic [IDX_W-1:0]    idx;
    logic [PPN_BITS-1:0] ppn [2];
    bank_cfg_t           cfg;
    logic                unused_spare;

    mmu_ctrl_regs #(.CFG_W(CFG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_data  (cfg_data),
        .boot_clr  (boot_clr),
        .dma_req   (dma_req),
        .bank_q    (bank_q),
        .boot_q    (boot_mode),
        .dma_own_q (dma_own_q)
    );

    // Index build: bank fields plus page number, with the bank field chosen by the bus owner.
    always_comb begin
        cfg = bank_cfg_t'(bank_q);
        idx = map_index(cfg, dma_own_q, addr_in[VA_BITS-1 -: PG_W]);
    end
    assign unused_spare = cfg.spare;

    // Two identical tables: index 0 for reads, index 1 for writes.
    for (genvar t = 0; t < 2; t++) begin : g_map
        mmu_page_table #(.IDX_W(IDX_W), .PPN_W(PPN_BITS), .DATA_W(TD_BITS)) u_tbl (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (tbl_we && (tbl_sel == 1'(t))),
            .waddr (tbl_addr),
            .wdata (tbl_wdata),
            .raddr (idx),
            .rdata (ppn[t])
        );
    end

    // Output join: physical page in front of the page offset.
    assign rd_phys   = {ppn[0], addr_in[OFS_BITS-1:0]};
    assign wr_phys   = {ppn[1], addr_in[OFS_BITS-1:0]};
    assign dma_grant = dma_own_q;
    assign cpu_hold  = dma_own_q;
endmodule

// File: tb/mmu_bank_mapper_bench.sv
module mmu_bank_mapper_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_data = '0;
    logic        boot_clr = 1'b0;
    logic        dma_req = 1'b0;
    logic        dma_grant, cpu_hold, boot_mode;
    logic        tbl_we = 1'b0;
    logic        tbl_sel = 1'b0;
    logic [8:0]  tbl_addr = '0;
    logic [7:0]  tbl_wdata = '0;
    logic [15:0] addr_in = '0;
    logic [17:0] rd_phys, wr_phys;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [5:0] m_rd [512];
    logic [5:0] m_wr [512];

    always #4 clk = ~clk;

    mmu_bank_mapper u_mmu_bank_mapper (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .boot_clr(boot_clr), .dma_req(dma_req), .dma_grant(dma_grant),
        .cpu_hold(cpu_hold), .boot_mode(boot_mode), .tbl_we(tbl_we),
        .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
        .addr_in(addr_in), .rd_phys(rd_phys), .wr_phys(wr_phys)
    );

    function automatic logic [8:0] exp_idx(logic [7:0] b, logic g, logic [15:0] a);
        logic [1:0] bk;
        bk = g ? b[7:6] : b[4:3];
        return {~b[5], b[2:1], bk, a[15:12]};
    endfunction

    function automatic logic [5:0] pat(bit s, int i);
        return s ? 6'((i * 13 + 5) ^ (i >> 3)) : 6'(i * 7 + 3);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tbl_write(bit s, int i, logic [7:0] d);
        tbl_we = 1'b1; tbl_sel = s; tbl_addr = 9'(i); tbl_wdata = d;
        @(negedge clk);
        tbl_we = 1'b0;
        if (s) m_wr[i] = d[5:0]; else m_rd[i] = d[5:0];
    endtask

    task automatic chk_map(string req, logic [7:0] b, logic g);
        logic [8:0] ix;
        ix = exp_idx(b, g, addr_in);
        chk(req, 32'(rd_phys), 32'({m_rd[ix], addr_in[11:0]}));
        chk(req, 32'(wr_phys), 32'({m_wr[ix], addr_in[11:0]}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        logic [17:0] r0, w0;
        void'($urandom(32'd4321));
        @(negedge clk);
        // Load both tables with upper junk bits, which the design must drop (R7)
        for (int i = 0; i < 512; i++) tbl_write(1'b0, i, {2'b11, pat(1'b0, i)});
        for (int i = 0; i < 512; i++) tbl_write(1'b1, i, {2'b10, pat(1'b1, i)});
        // R1: reset state
        chk("R1 boot", 32'(boot_mode), 1);
        chk("R1 grant", 32'(dma_grant), 0);
        chk("R1 hold", 32'(cpu_hold), 0);
        rst_n = 1'b1;
        for (int p = 0; p < 16; p++) begin
            addr_in = {4'(p), 12'(p * 97)};
            #1;
            chk_map("R1 R3 R7 bank zero", 8'h00, 1'b0);
        end
        // Random mix (R2 R3 R4 R5 R7)
        b = 8'h00;
        for (int k = 0; k < 400; k++) begin
            logic g;
            cfg_wr = ($urandom % 3) != 0;
            cfg_data = 8'($urandom);
            dma_req = $urandom % 2;
            addr_in = 16'($urandom);
            if (cfg_wr) b = cfg_data;
            g = dma_req;
            @(negedge clk);
            cfg_wr = 1'b0;
            chk("R5 grant", 32'(dma_grant), 32'(g));
            chk("R5 hold", 32'(cpu_hold), 32'(g));
            chk_map(g ? "R4 dma map" : "R3 cpu map", b, g);
        end
        // R4/R5: same step as the grant, with distinct CPU and DMA banks
        cfg_wr = 1'b1; cfg_data = 8'b10_1_01_11_0; dma_req = 1'b0; addr_in = 16'h7abc;
        @(negedge clk); cfg_wr = 1'b0; b = 8'b10_1_01_11_0;
        chk_map("R3 cpu bank", b, 1'b0);
        dma_req = 1'b1;
        #1; chk_map("R5 no grant before edge", b, 1'b0);
        @(negedge clk);
        chk("R5 grant rise", 32'(dma_grant), 1);
        chk_map("R4 dma bank", b, 1'b1);
        dma_req = 1'b0;
        @(negedge clk);
        chk("R5 grant fall", 32'(dma_grant), 0);
        chk_map("R5 cpu restored", b, 1'b0);
        // R9: bit 0 has no effect
        r0 = rd_phys; w0 = wr_phys;
        cfg_wr = 1'b1; cfg_data = b ^ 8'h01;
        @(negedge clk); cfg_wr = 1'b0;
        chk("R9 rd", 32'(rd_phys), 32'(r0));
        chk("R9 wr", 32'(wr_phys), 32'(w0));
        b = b ^ 8'h01;
        // R2: cfg_data without strobe is ignored
        cfg_data = ~b;
        @(negedge clk); @(negedge clk);
        chk_map("R2 no strobe", b, 1'b0);
        // R6: write-table update leaves the read table alone
        begin
            logic [8:0] ix;
            ix = exp_idx(b, 1'b0, addr_in);
            r0 = rd_phys;
            tbl_write(1'b1, int'(ix), 8'hff ^ {2'b00, m_wr[ix]});
            chk("R6 rd untouched", 32'(rd_phys), 32'(r0));
            chk("R6 R7 wr updated", 32'(wr_phys[17:12]), 32'(m_wr[ix]));
            tbl_write(1'b0, int'(ix), 8'h40 | {2'b00, ~m_rd[ix]});
            chk("R6 R7 rd updated", 32'(rd_phys[17:12]), 32'(m_rd[ix]));
            chk("R6 wr untouched", 32'(wr_phys[17:12]), 32'(m_wr[ix]));
        end
        // R8: boot flag clear is sticky
        chk("R8 boot before", 32'(boot_mode), 1);
        boot_clr = 1'b1; @(negedge clk); boot_clr = 1'b0;
        chk("R8 boot cleared", 32'(boot_mode), 0);
        repeat (3) @(negedge clk);
        chk("R8 boot stays", 32'(boot_mode), 0);
        // R1: second reset restores state and the bank-zero mapping
        dma_req = 1'b1; @(negedge clk);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; dma_req = 1'b0;
        chk("R1 boot again", 32'(boot_mode), 1);
        chk("R1 grant again", 32'(dma_grant), 0);
        chk_map("R1 bank cleared", 8'h00, 1'b0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule